// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a two-dimensional rectangle engine for a linear framebuffer. Software sets up a small register file with the source and destination positions, the rectangle size, the surface base addresses and row pitches, the pixel depth and a foreground colour. A write to the command register then launches one operation. The engine walks the destination rectangle one pixel at a time over a synchronous memory port with a request/ready handshake. Each pixel is either filled from a raster code or copied from the matching source pixel.

A copy inside one surface stays correct when source and destination overlap. Software picks the traversal direction with two command bits. When a direction bit is set, the programmed coordinate is taken as the far edge (rightmost column or bottom row), and the engine steps toward lower coordinates on that axis. A busy flag in the status register is high from the accepted command until the final pixel write completes. While it is high, the register file is frozen.

Top module: `rect_blit_engine`

## Requirements
- R1: Registers are selected by word index: 0 command, 1 source position, 2 destination position, 3 size, 4 source base, 5 destination base, 6 pitch, 7 mode, 8 foreground, 9 status (bit 0 = busy). Positions hold x in bits 11:0 and y in bits 27:16. Size holds width-1 in bits 11:0 and height-1 in bits 27:16. Bases hold the byte address divided by 8 in bits 25:0, and bits 31:26 read as zero. Pitch holds the source pitch/8 in bits 10:0 and the destination pitch/8 in bits 26:16. All registers read 0 after reset, and unused bits read 0.
- R2: A legal command write sets busy in the next cycle. Busy stays high until the write of the last pixel is accepted, and then it returns low. Exactly width×height pixel writes are issued, and no memory request is made while the engine is idle.
- R3: While busy is high, every register write is ignored, including a further command write.
- R4: A command is rejected, leaving busy low and memory untouched, in any of these cases: op field (bits 1:0) is not 01 (fill) or 10 (copy); a fill's raster code is not 0x00, 0x5A, 0xF0 or 0xFF; a copy's code is not 0xCC; mode bits 1:0 are nonzero; or the mode depth field is 3. The command register keeps the last accepted command.
- R5: The byte address of pixel (x, y) is base×8 + y×pitch×8 + x×bytes-per-pixel, where base and pitch are the register values.
- R6: Mode bits 9:8 select the depth: 0 = 8, 1 = 16, 2 = 32 bits per pixel. The pixel sits in the low bits of the 32-bit memory word, the bits above it are written as zero, and only the pixel's bytes change.
- R7: Fill raster codes are in command bits 31:24: 0x00 writes zero, 0xFF writes all ones, 0xF0 writes the foreground colour, and 0x5A writes the foreground XOR the old destination pixel.
- R8: A 0x5A fill reads each destination pixel before writing it. The other fills perform no memory reads.
- R9: A copy (code 0xCC) reads each source pixel and writes it to the matching destination pixel.
- R10: Command bit 15 makes the engine traverse right-to-left and bit 14 bottom-to-top. With a bit set, the programmed x or y of both rectangles is the last column or row. Overlapping copies are therefore correct when software sets a bit on each axis where the source lies before the destination.
- R11: A memory request holds its address, direction and write data stable until ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the pixel |
| mem_wdata | output | 32 | Pixel write data, low-aligned |
| mem_rdata | input | 32 | Read data, valid while mem_req, !mem_we and mem_ready are high |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
The assertions check the following on every cycle:
- the request stays stable until it is accepted;
- no request is made while idle;
- busy can only rise after a command write;
- 8- and 16-bit pixels leave the upper data bits clear.

Only the bench scenarios can show the rest, by comparing the whole framebuffer against a reference model:
- the final pixel values;
- the address formula;
- overlap correctness under each traversal direction;
- rejection of illegal commands;
- the freezing of registers during an operation.

// File: rtl/rbe_pkg.sv
package rbe_pkg;

    typedef enum logic [3:0] {
        RG_CMD      = 4'd0,
        RG_SRC_XY   = 4'd1,
        RG_DST_XY   = 4'd2,
        RG_SIZE     = 4'd3,
        RG_SRC_BASE = 4'd4,
        RG_DST_BASE = 4'd5,
        RG_PITCH    = 4'd6,
        RG_MODE     = 4'd7,
        RG_FG       = 4'd8,
        RG_STATUS   = 4'd9
    } reg_idx_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_FILL = 2'd1,
        OP_COPY = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    localparam logic [7:0] ROP_ZERO = 8'h00;
    localparam logic [7:0] ROP_ONES = 8'hFF;
    localparam logic [7:0] ROP_FG   = 8'hF0;
    localparam logic [7:0] ROP_XOR  = 8'h5A;
    localparam logic [7:0] ROP_SRC  = 8'hCC;

    typedef struct packed {
        logic [7:0] rop;
        logic       rev_x;
        logic       rev_y;
        op_e        op;
    } job_t;

    function automatic job_t decode_cmd(input logic [31:0] w);
        job_t j;
        j.rop   = w[31:24];
        j.rev_x = w[15];
        j.rev_y = w[14];
        j.op    = op_e'(w[1:0]);
        return j;
    endfunction

    function automatic logic fill_rop_ok(input logic [7:0] r);
        return (r == ROP_ZERO) || (r == ROP_ONES) || (r == ROP_FG) || (r == ROP_XOR);
    endfunction

    function automatic logic cmd_legal(input job_t j, input logic [1:0] rot,
                                       input logic [1:0] depth);
        logic op_ok;
        op_ok = ((j.op == OP_FILL) && fill_rop_ok(j.rop)) ||
                ((j.op == OP_COPY) && (j.rop == ROP_SRC));
        return op_ok && (rot == 2'b00) && (depth != 2'd3);
    endfunction

    function automatic logic need_read(input job_t j);
        return (j.op == OP_COPY) || (j.rop == ROP_XOR);
    endfunction

    function automatic logic [31:0] depth_mask(input logic [1:0] depth);
        case (depth)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] fill_pixel(input logic [7:0] rop, input logic [31:0] fg,
                                               input logic [31:0] old, input logic [31:0] mask);
        case (rop)
            ROP_ZERO: return 32'h0;
            ROP_ONES: return mask;
            ROP_FG:   return fg & mask;
            default:  return (fg ^ old) & mask;
        endcase
    endfunction

endpackage

// File: rtl/rbe_regs.sv
module rbe_regs
    import rbe_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int PITCH_W = 11,
    parameter int BASE_W  = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    input  logic               busy,
    output logic [31:0]        rdata,
    output logic               start,
    output job_t               start_job,
    output job_t               job,
    output logic [COORD_W-1:0] src_x,
    output logic [COORD_W-1:0] src_y,
    output logic [COORD_W-1:0] dst_x,
    output logic [COORD_W-1:0] dst_y,
    output logic [COORD_W-1:0] w_m1,
    output logic [COORD_W-1:0] h_m1,
    output logic [BASE_W-1:0]  src_base,
    output logic [BASE_W-1:0]  dst_base,
    output logic [PITCH_W-1:0] src_pitch,
    output logic [PITCH_W-1:0] dst_pitch,
    output logic [1:0]         depth,
    output logic [31:0]        fg
);
    localparam int HI = 16;

    logic [31:0] cmd_q;
    logic [1:0]  rot_q;

    function automatic logic [31:0] pair_c(input logic [COORD_W-1:0] lo,
                                           input logic [COORD_W-1:0] hi);
        logic [31:0] r;
        r = '0;
        r[COORD_W-1:0]       = lo;
        r[HI+COORD_W-1:HI]   = hi;
        return r;
    endfunction

    assign start_job = decode_cmd(wdata);
    assign job       = decode_cmd(cmd_q);
    assign start     = we && !busy && (addr == RG_CMD) &&
                       cmd_legal(start_job, rot_q, depth);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            src_x     <= '0;
            src_y     <= '0;
            dst_x     <= '0;
            dst_y     <= '0;
            w_m1      <= '0;
            h_m1      <= '0;
            src_base  <= '0;
            dst_base  <= '0;
            src_pitch <= '0;
            dst_pitch <= '0;
            rot_q     <= '0;
            depth     <= '0;
            fg        <= '0;
        end else if (we && !busy) begin
            case (addr)
                RG_CMD:      if (start) cmd_q <= wdata;
                RG_SRC_XY: begin
                    src_x <= wdata[COORD_W-1:0];
                    src_y <= wdata[HI+COORD_W-1:HI];
                end
                RG_DST_XY: begin
                    dst_x <= wdata[COORD_W-1:0];
                    dst_y <= wdata[HI+COORD_W-1:HI];
                end
                RG_SIZE: begin
                    w_m1 <= wdata[COORD_W-1:0];
                    h_m1 <= wdata[HI+COORD_W-1:HI];
                end
                RG_SRC_BASE: src_base <= wdata[BASE_W-1:0];
                RG_DST_BASE: dst_base <= wdata[BASE_W-1:0];
                RG_PITCH: begin
                    src_pitch <= wdata[PITCH_W-1:0];
                    dst_pitch <= wdata[HI+PITCH_W-1:HI];
                end
                RG_MODE: begin
                    rot_q <= wdata[1:0];
                    depth <= wdata[9:8];
                end
                RG_FG:       fg <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RG_CMD:      rdata = cmd_q;
            RG_SRC_XY:   rdata = pair_c(src_x, src_y);
            RG_DST_XY:   rdata = pair_c(dst_x, dst_y);
            RG_SIZE:     rdata = pair_c(w_m1, h_m1);
            RG_SRC_BASE: rdata[BASE_W-1:0] = src_base;
            RG_DST_BASE: rdata[BASE_W-1:0] = dst_base;
            RG_PITCH: begin
                rdata[PITCH_W-1:0]       = src_pitch;
                rdata[HI+PITCH_W-1:HI]   = dst_pitch;
            end
            RG_MODE: begin
                rdata[1:0] = rot_q;
                rdata[9:8] = depth;
            end
            RG_FG:       rdata = fg;
            RG_STATUS:   rdata[0] = busy;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/rbe_walker.sv
module rbe_walker #(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic               rev_x,
    input  logic               rev_y,
    input  logic [COORD_W-1:0] w_m1,
    input  logic [COORD_W-1:0] h_m1,
    input  logic [COORD_W-1:0] sx,
    input  logic [COORD_W-1:0] sy,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    output logic [COORD_W-1:0] cur_sx,
    output logic [COORD_W-1:0] cur_sy,
    output logic [COORD_W-1:0] cur_dx,
    output logic [COORD_W-1:0] cur_dy,
    output logic               last
);
    logic [COORD_W-1:0] col, row;
    logic               end_col;

    function automatic logic [COORD_W-1:0] walk(input logic [COORD_W-1:0] start,
                                                input logic [COORD_W-1:0] off,
                                                input logic rev);
        return rev ? start - off : start + off;
    endfunction

    assign end_col = (col == w_m1);
    assign last    = end_col && (row == h_m1);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            if (end_col) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    assign cur_sx = walk(sx, col, rev_x);
    assign cur_dx = walk(dx, col, rev_x);
    assign cur_sy = walk(sy, row, rev_y);
    assign cur_dy = walk(dy, row, rev_y);

endmodule

// File: rtl/rbe_addr.sv
module rbe_addr #(
    parameter int COORD_W = 12,
    parameter int PITCH_W = 11,
    parameter int BASE_W  = 26,
    parameter int ADDR_W  = 32
) (
    input  logic [BASE_W-1:0]  base,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [1:0]         depth,
    output logic [ADDR_W-1:0]  addr
);
    localparam int ROW_W = COORD_W + PITCH_W + 3;
    localparam int COL_W = COORD_W + 2;

    logic [ROW_W-1:0] row_off;
    logic [COL_W-1:0] col_off;

    assign row_off = ROW_W'(y) * ROW_W'({pitch, 3'b000});

    always_comb begin
        case (depth)
            2'd0:    col_off = COL_W'(x);
            2'd1:    col_off = COL_W'({x, 1'b0});
            default: col_off = {x, 2'b00};
        endcase
    end

    assign addr = ADDR_W'({base, 3'b000}) + ADDR_W'(row_off) + ADDR_W'(col_off);

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import rbe_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int PITCH_W = 11,
    parameter int BASE_W  = 26,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready
);
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} st_e;

    st_e state;
    logic busy;
    logic start, last, step;
    job_t start_job, job;
    logic [COORD_W-1:0] src_x, src_y, dst_x, dst_y, w_m1, h_m1;
    logic [COORD_W-1:0] cur_sx, cur_sy, cur_dx, cur_dy;
    logic [BASE_W-1:0]  src_base, dst_base;
    logic [PITCH_W-1:0] src_pitch, dst_pitch;
    logic [1:0]         px_depth;
    logic [31:0]        fg, px_mask, rd_q;
    logic [ADDR_W-1:0]  src_addr, dst_addr;
    logic               is_copy, rd_needed;

    assign busy      = (state != ST_IDLE);
    assign px_mask   = depth_mask(px_depth);
    assign is_copy   = (job.op == OP_COPY);
    assign rd_needed = need_read(job);

    rbe_regs #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .busy(busy), .rdata(cfg_rdata), .start(start), .start_job(start_job),
        .job(job), .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .w_m1(w_m1), .h_m1(h_m1), .src_base(src_base), .dst_base(dst_base),
        .src_pitch(src_pitch), .dst_pitch(dst_pitch), .depth(px_depth), .fg(fg)
    );

    rbe_walker #(.COORD_W(COORD_W)) u_walk (
        .clk(clk), .rst(rst), .load(start), .step(step),
        .rev_x(job.rev_x), .rev_y(job.rev_y), .w_m1(w_m1), .h_m1(h_m1),
        .sx(src_x), .sy(src_y), .dx(dst_x), .dy(dst_y),
        .cur_sx(cur_sx), .cur_sy(cur_sy), .cur_dx(cur_dx), .cur_dy(cur_dy),
        .last(last)
    );

    rbe_addr #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W))
    u_src_addr (
        .base(src_base), .pitch(src_pitch), .x(cur_sx), .y(cur_sy),
        .depth(px_depth), .addr(src_addr)
    );

    rbe_addr #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W))
    u_dst_addr (
        .base(dst_base), .pitch(dst_pitch), .x(cur_dx), .y(cur_dy),
        .depth(px_depth), .addr(dst_addr)
    );

    assign step = (state == ST_WRITE) && mem_ready && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rd_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start)
                        state <= need_read(start_job) ? ST_READ : ST_WRITE;
                end
                ST_READ: begin
                    if (mem_ready) begin
                        rd_q  <= mem_rdata & px_mask;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        if (last)           state <= ST_IDLE;
                        else if (rd_needed) state <= ST_READ;
                        else                state <= ST_WRITE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_READ && is_copy) ? src_addr : dst_addr;
        mem_wdata = is_copy ? rd_q : fill_pixel(job.rop, fg, rd_q, px_mask);
    end

endmodule

// File: rtl/rbe_checker.sv
module rbe_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        cfg_we,
    input logic [3:0]  cfg_addr,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [1:0]  px_depth
);
    // R11: request held stable until accepted
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata));

    // R2: no memory traffic while idle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R2: busy only rises after a command-register write
    a_r2_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cfg_we && cfg_addr == 4'd0));

    // R6: 8-bit pixels leave upper data bits clear
    a_r6_pack8: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && px_depth == 2'd0 |-> mem_wdata[31:8] == 24'h0);

    // R6: 16-bit pixels leave upper data bits clear
    a_r6_pack16: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && px_depth == 2'd1 |-> mem_wdata[31:16] == 16'h0);

endmodule

bind rect_blit_engine rbe_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .px_depth(px_depth)
);

// File: tb/rect_blit_engine_test.sv
module rect_blit_engine_test;
    localparam int MSZ = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = 4'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0] mem_b [0:MSZ-1];
    logic [7:0] ref_b [0:MSZ-1];
    int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0, bpb = 1;

    always #10 clk = ~clk;

    rect_blit_engine uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) ^ (i >> 5));
    endfunction

    function automatic int mi(int a);
        return a & (MSZ - 1);
    endfunction

    assign mem_rdata = {mem_b[mi(int'(mem_addr) + 3)], mem_b[mi(int'(mem_addr) + 2)],
                        mem_b[mi(int'(mem_addr) + 1)], mem_b[mi(int'(mem_addr))]};

    always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MSZ; i++) mem_b[i] = pat(i);
        end else if (mem_req && mem_ready) begin
            if (mem_we) begin
                for (int k = 0; k < bpb; k++)
                    mem_b[mi(int'(mem_addr) + k)] = mem_wdata[8*k +: 8];
                n_wr++;
            end else begin
                n_rd++;
            end
        end
    end

    task automatic chk(input bit c, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rreg(input int a, output logic [31:0] d);
        cfg_addr = 4'(a);
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] s;
        int n = 0;
        rreg(9, s);
        while (s[0] && n < 6000) begin
            @(negedge clk);
            rreg(9, s);
            n++;
        end
        chk(!s[0], tag, s, 0);
    endtask

    task automatic cmp_mem(input string tag);
        int bad = 0, first = 0;
        for (int i = 0; i < MSZ; i++)
            if (mem_b[i] !== ref_b[i]) begin
                if (bad == 0) first = i;
                bad++;
            end
        chk(bad == 0, tag, {24'h0, mem_b[first]}, {24'h0, ref_b[first]});
    endtask

    function automatic logic [31:0] ref_get(int a);
        logic [31:0] r = 0;
        for (int k = 0; k < bpb; k++) r[8*k +: 8] = ref_b[mi(a + k)];
        return r;
    endfunction

    task automatic ref_set(input int a, input logic [31:0] v);
        for (int k = 0; k < bpb; k++) ref_b[mi(a + k)] = v[8*k +: 8];
    endtask

    function automatic logic [31:0] msk();
        return bpb == 1 ? 32'hFF : bpb == 2 ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic set_mode(input int depth);
        wreg(7, 32'(depth) << 8);
        bpb = 1 << depth;
    endtask

    task automatic run_fill(input int depth, input int base, input int pitch, input int x,
                            input int y, input int w, input int h, input logic [7:0] rop,
                            input logic [31:0] fg, input string tag);
        logic [31:0] s, v, o;
        int r0, w0;
        set_mode(depth);
        wreg(5, 32'(base / 8));
        wreg(6, 32'(pitch / 8) << 16);
        wreg(2, 32'(x) | (32'(y) << 16));
        wreg(3, 32'(w - 1) | (32'(h - 1) << 16));
        wreg(8, fg);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) begin
                int a = base + (y + r) * pitch + (x + c) * bpb;
                o = ref_get(a);
                case (rop)
                    8'h00: v = 0;
                    8'hFF: v = msk();
                    8'hF0: v = fg & msk();
                    default: v = (fg ^ o) & msk();
                endcase
                ref_set(a, v);
            end
        r0 = n_rd; w0 = n_wr;
        wreg(0, {rop, 22'h0, 2'b01});
        rreg(9, s);
        chk(s[0], "R2 busy after command", s, 1);
        wait_idle("R2 busy clears");
        cmp_mem(tag);
        chk(n_wr - w0 == w * h, "R2 write count", n_wr - w0, w * h);
        chk(n_rd - r0 == (rop == 8'h5A ? w * h : 0), "R8 read count", n_rd - r0,
            rop == 8'h5A ? w * h : 0);
    endtask

    task automatic run_copy(input int depth, input int sb, input int sp, input int sx,
                            input int sy, input int db, input int dp, input int dx,
                            input int dy, input int w, input int h, input bit force_rev,
                            input string tag);
        logic [31:0] tmp [0:255];
        bit rx, ry;
        int r0, w0, px, py, qx, qy;
        set_mode(depth);
        rx = force_rev || (sb == db && sx < dx);
        ry = force_rev || (sb == db && sy < dy);
        px = rx ? sx + w - 1 : sx;  py = ry ? sy + h - 1 : sy;
        qx = rx ? dx + w - 1 : dx;  qy = ry ? dy + h - 1 : dy;
        wreg(4, 32'(sb / 8));
        wreg(5, 32'(db / 8));
        wreg(6, 32'(sp / 8) | (32'(dp / 8) << 16));
        wreg(1, 32'(px) | (32'(py) << 16));
        wreg(2, 32'(qx) | (32'(qy) << 16));
        wreg(3, 32'(w - 1) | (32'(h - 1) << 16));
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                tmp[r * w + c] = ref_get(sb + (sy + r) * sp + (sx + c) * bpb);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                ref_set(db + (dy + r) * dp + (dx + c) * bpb, tmp[r * w + c]);
        r0 = n_rd; w0 = n_wr;
        wreg(0, 32'hCC00_0002 | (32'(rx) << 15) | (32'(ry) << 14));
        wait_idle("R2 copy completes");
        cmp_mem(tag);
        chk(n_rd - r0 == w * h && n_wr - w0 == w * h, "R9 copy access counts",
            n_rd - r0, w * h);
    endtask

    task automatic try_reject(input logic [31:0] cmd, input logic [31:0] mode,
                              input string tag);
        logic [31:0] s, c0, c1;
        int r0, w0;
        wreg(7, mode);
        rreg(0, c0);
        r0 = n_rd; w0 = n_wr;
        wreg(0, cmd);
        rreg(9, s);
        repeat (4) @(negedge clk);
        rreg(0, c1);
        chk(!s[0] && n_rd == r0 && n_wr == w0 && c1 == c0, tag, s, 0);
        cmp_mem(tag);
        set_mode(0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d, s;
        bit all0;
        void'($urandom(32'd4242));
        for (int i = 0; i < MSZ; i++) ref_b[i] = pat(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        all0 = 1;
        for (int a = 0; a < 10; a++) begin
            rreg(a, d);
            if (d != 0) all0 = 0;
        end
        chk(all0, "R1 reset values", 0, 0);

        // R1 field layout readback
        wreg(1, 32'hFFFF_FFFF); rreg(1, d);
        chk(d == 32'h0FFF_0FFF, "R1 position fields", d, 32'h0FFF_0FFF);
        wreg(3, 32'hFFFF_FFFF); rreg(3, d);
        chk(d == 32'h0FFF_0FFF, "R1 size fields", d, 32'h0FFF_0FFF);
        wreg(4, 32'hFFFF_FFFF); rreg(4, d);
        chk(d == 32'h03FF_FFFF, "R1 base upper bits zero", d, 32'h03FF_FFFF);
        wreg(6, 32'hFFFF_FFFF); rreg(6, d);
        chk(d == 32'h07FF_07FF, "R1 pitch fields", d, 32'h07FF_07FF);
        wreg(7, 32'hFFFF_FFFF); rreg(7, d);
        chk(d == 32'h0000_0303, "R1 mode fields", d, 32'h303);
        set_mode(0);

        // fills
        run_fill(0, 0,    64,  2, 1, 5, 3, 8'hF0, 32'h1234_56A7, "R7 fill fg 8bpp");
        run_fill(1, 512,  48,  3, 2, 4, 4, 8'h00, 32'h0,         "R5 fill zero 16bpp offset");
        run_fill(2, 1024, 96,  1, 3, 6, 2, 8'hFF, 32'h0,         "R7 fill ones 32bpp");
        run_fill(1, 2048, 40,  0, 0, 7, 3, 8'h5A, 32'h0000_F00F, "R8 xor fill 16bpp");
        run_fill(0, 3072, 16,  5, 4, 3, 2, 8'hFF, 32'h0,         "R6 8bpp neighbours intact");
        run_fill(2, 3584, 8,   0, 0, 1, 1, 8'h5A, 32'hDEAD_BEEF, "R7 single pixel xor");

        // copies
        run_copy(2, 4096, 64, 1, 1, 5120, 80, 2, 3, 6, 4, 1'b0, "R9 copy 32bpp");
        run_copy(1, 4096, 64, 0, 0, 5632, 64, 4, 1, 5, 3, 1'b1, "R10 reversed non-overlap copy");
        run_copy(0, 6144, 32, 2, 1, 6144, 32, 3, 1, 8, 2, 1'b0, "R10 overlap right shift");
        run_copy(1, 6144, 64, 1, 1, 6144, 64, 3, 3, 6, 5, 1'b0, "R10 overlap down-right");
        run_copy(2, 6144, 96, 4, 4, 6144, 96, 1, 2, 5, 4, 1'b0, "R10 overlap up-left");

        // rejections
        try_reject(32'h3300_0001, 32'h0,   "R4 bad fill code");
        try_reject(32'hF000_0003, 32'h0,   "R4 bad op field");
        try_reject(32'h0000_0002, 32'h0,   "R4 copy needs 0xCC");
        try_reject(32'hF000_0001, 32'h1,   "R4 rotation bits");
        try_reject(32'hF000_0001, 32'h300, "R4 depth code 3");

        // R3 writes ignored while busy
        set_mode(2);
        wreg(5, 32'(1536 / 8));
        wreg(6, 32'(128 / 8) << 16);
        wreg(2, 32'h0);
        wreg(3, 32'(15) | (32'(7) << 16));
        wreg(8, 32'hA5A5_0F0F);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 16; c++) ref_set(1536 + r * 128 + c * 4, 32'hA5A5_0F0F);
        wreg(0, 32'hF000_0001);
        wreg(0, 32'hFF00_0001);
        wreg(5, 32'h10);
        rreg(9, s);
        chk(s[0], "R3 still busy", s, 1);
        wait_idle("R3 finish");
        cmp_mem("R3 second command ignored");
        rreg(5, d);
        chk(d == 32'(1536 / 8), "R3 base write ignored", d, 1536 / 8);
        rreg(0, d);
        chk(d == 32'hF000_0001, "R3 command readback", d, 32'hF000_0001);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int dep, w, h, x, y, b, p;
            logic [7:0] rops [4] = '{8'h00, 8'h5A, 8'hF0, 8'hFF};
            dep = $urandom % 3;
            w = 1 + $urandom % 12; h = 1 + $urandom % 6;
            x = $urandom % 8;     y = $urandom % 6;
            b = 8 * ($urandom % 256);
            p = (((x + w + 8) * 4 + 7) & ~7) + 8 * ($urandom % 3);
            if ($urandom % 2)
                run_fill(dep, b, p, x, y, w, h, rops[$urandom % 4], $urandom, "R7 random fill");
            else
                run_copy(dep, b, p, x, y, b, p, $urandom % 8, $urandom % 6, w, h, 1'b0,
                         "R10 random same-surface copy");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule